// File: doc/BRIEF.md
# Selectable Periodic Rate Divider

The block turns a reference clock, presented as a one-cycle enable pulse per reference period, into three timing outputs: a one-cycle periodic pulse at a programmable rate, a 50% square wave at the same rate, and a one-second tick used to advance timekeeping. A 3-bit divider-control input names the reference frequency: 4.194304 MHz, 1.048576 MHz or 32.768 kHz. The same input can instead hold the whole divider chain cleared. A 4-bit rate input picks the output rate. Code 0 turns the rate outputs off. Codes 3 to 15 give 65536 Hz shifted right by the code, down to 2 Hz. Codes 1 and 2 depend on the reference.

Internally the reference enable advances one binary chain. The reference selection fixes how many low stages make up the prescaler to a common 32768 Hz base. The rate code picks which stage the pulse and the square wave are taken from. Leaving the hold state restarts the chain from zero. The first one-second tick then comes half a second later, and one more comes every second after that.

Top module: `periodic_rate_divider`

## Requirements
- R1: Reset drives all outputs low. Divider-control codes 3 to 7 hold the chain cleared. While held, per_pulse, per_irq and sec_tick stay low and sqw_out is low. On a return to codes 0 to 2 the chain counts again from zero, so the first pulse arrives after one full period.
- R2: Divider-control codes 0, 1 and 2 give P = 7, 5 and 0. This means 2^P reference ticks per 32768 Hz base tick. For rate codes r from 3 to 15 the period is 2^(P+r-1) reference ticks.
- R3: With divider-control codes 0 or 1, rate codes 1 and 2 give periods of 2^P and 2^(P+1) reference ticks. With code 2, rate codes 1 and 2 give periods of 128 and 256 reference ticks (256 Hz and 128 Hz).
- R4: Rate code 0 keeps per_pulse, per_irq and sqw_out low.
- R5: per_pulse is high for exactly one clock cycle. That cycle directly follows the cycle in which ref_en completes a period. Periods are counted in reference ticks from the chain restart.
- R6: per_irq equals per_pulse while pie_en is 1 and stays low while pie_en is 0.
- R7: When sqw_en is 1, a reference is selected and the rate code is not 0, sqw_out is low for the first half of each period and high for the second half. It falls in the same cycle that per_pulse rises. Otherwise sqw_out is low.
- R8: sec_tick pulses for one cycle after ref_en completes 2^(P+14) reference ticks since the chain restart (half a second). It then pulses again every 2^(P+15) reference ticks, independent of the rate code.
- R9: While ref_en is 0 the chain does not advance, and no pulse or tick is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_en | input | 1 | One-cycle enable per reference clock period |
| div_ctl | input | 3 | Reference selection (0, 1, 2) or chain hold (3 to 7) |
| rate_sel | input | 4 | Output rate code, 0 turns the rate outputs off |
| sqw_en | input | 1 | Square-wave output enable |
| pie_en | input | 1 | Gate for the periodic pulse onto per_irq |
| per_pulse | output | 1 | One-cycle pulse at the selected rate |
| per_irq | output | 1 | per_pulse gated by pie_en |
| sqw_out | output | 1 | 50% square wave at the selected rate |
| sec_tick | output | 1 | One-cycle pulse once per second |

## Verification
Any wrong count or wrong stage selection in the chain moves the phase of per_pulse and sqw_out. At the fastest settings this shows within a few reference ticks. A fault in the upper stages shows only in sec_tick, which needs the long half-second run at the 32.768 kHz selection. The bench keeps a model count of reference ticks since the last chain restart, and it compares all four outputs on every cycle. A skipped clear, a stage index off by one or a stall that still advances the chain therefore shows at the next expected pulse edge. Directed cases pin down the absolute periods for each reference, the low-code exceptions, and the restart phase after a hold.

// File: rtl/prd_pkg.sv
package prd_pkg;

   typedef enum logic [1:0] {
      PRD_REF_FAST = 2'd0,
      PRD_REF_MID  = 2'd1,
      PRD_REF_SLOW = 2'd2,
      PRD_REF_HOLD = 2'd3
   } prd_ref_e;

endpackage

// File: rtl/prd_ctl_decode.sv
module prd_ctl_decode
   import prd_pkg::*;
#(
   parameter int PRE_FAST = 7,
   parameter int PRE_MID  = 5,
   parameter int PRE_SLOW = 0,
   parameter int IDX_W    = 5
) (
   input  logic [2:0]       div_ctl,
   output prd_ref_e         ref_kind,
   output logic             active,
   output logic [IDX_W-1:0] pre_log2
);

   always_comb begin
      case (div_ctl)
         3'd0:    ref_kind = PRD_REF_FAST;
         3'd1:    ref_kind = PRD_REF_MID;
         3'd2:    ref_kind = PRD_REF_SLOW;
         default: ref_kind = PRD_REF_HOLD;
      endcase
      active = (ref_kind != PRD_REF_HOLD);
      case (ref_kind)
         PRD_REF_FAST: pre_log2 = IDX_W'(PRE_FAST);
         PRD_REF_MID:  pre_log2 = IDX_W'(PRE_MID);
         PRD_REF_SLOW: pre_log2 = IDX_W'(PRE_SLOW);
         default:      pre_log2 = '0;
      endcase
   end

endmodule

// File: rtl/prd_rate_map.sv
module prd_rate_map
   import prd_pkg::*;
#(
   parameter int RATE_W         = 4,
   parameter int SLOW_R1_LOG2   = 7,
   parameter int SLOW_LOW_CODES = 2,
   parameter int IDX_W          = 5
) (
   input  logic [RATE_W-1:0] rate_sel,
   input  prd_ref_e          ref_kind,
   input  logic [IDX_W-1:0]  pre_log2,
   output logic              rate_on,
   output logic [IDX_W-1:0]  tap_idx
);

   localparam logic [IDX_W-1:0]  ONE_I     = IDX_W'(1);
   localparam logic [IDX_W-1:0]  SLOW_BASE = IDX_W'(SLOW_R1_LOG2);
   localparam logic [RATE_W-1:0] LOW_LIMIT = RATE_W'(SLOW_LOW_CODES);

   logic [IDX_W-1:0] rate_ext;
   logic [IDX_W-1:0] stage;

   always_comb begin
      rate_ext = IDX_W'(rate_sel);
      rate_on  = |rate_sel;
      if (ref_kind == PRD_REF_SLOW && rate_sel <= LOW_LIMIT) begin
         stage = SLOW_BASE + rate_ext - ONE_I;
      end else begin
         stage = rate_ext - ONE_I;
      end
      tap_idx = pre_log2 + stage;
   end

endmodule

// File: rtl/prd_chain.sv
module prd_chain #(
   parameter int CNT_W = 22
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W:0]   ones_below
);

   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (adv) begin
         cnt <= cnt + CNT_ONE;
      end
   end

   assign ones_below[0] = 1'b1;
   for (genvar i = 1; i <= CNT_W; i++) begin : g_ones
      assign ones_below[i] = &cnt[i-1:0];
   end

   AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !clr) |=> (cnt == $past(cnt)))
      else $error("chain moved without reference tick"); // R9

   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0))
      else $error("chain not emptied by hold"); // R1

endmodule

// File: rtl/periodic_rate_divider.sv
module periodic_rate_divider
   import prd_pkg::*;
#(
   parameter int PRE_FAST       = 7,
   parameter int PRE_MID        = 5,
   parameter int PRE_SLOW       = 0,
   parameter int RATE_W         = 4,
   parameter int SLOW_R1_LOG2   = 7,
   parameter int SLOW_LOW_CODES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_en,
   input  logic [2:0]        div_ctl,
   input  logic [RATE_W-1:0] rate_sel,
   input  logic              sqw_en,
   input  logic              pie_en,
   output logic              per_pulse,
   output logic              per_irq,
   output logic              sqw_out,
   output logic              sec_tick
);

   localparam int CHAIN_W = (1 << RATE_W) - 1;
   localparam int CNT_W   = PRE_FAST + CHAIN_W;
   localparam int IDX_W   = $clog2(CNT_W + 1);
   localparam logic [IDX_W-1:0] ONE_I     = IDX_W'(1);
   localparam logic [IDX_W-1:0] SEC_SHIFT = IDX_W'(CHAIN_W - 1);

   if (!(PRE_SLOW < PRE_MID && PRE_MID < PRE_FAST)) begin : g_bad_pre
      $error("prescaler depths must rise from slow to fast reference");
   end
   if (IDX_W <= RATE_W) begin : g_bad_idx
      $error("tap index too narrow for rate field");
   end
   if (PRE_SLOW + SLOW_R1_LOG2 + SLOW_LOW_CODES > CNT_W) begin : g_bad_slow
      $error("slow low-code taps exceed chain");
   end

   prd_ref_e          ref_kind;
   logic              active;
   logic [IDX_W-1:0]  pre_log2;
   logic              rate_on;
   logic [IDX_W-1:0]  tap_idx;
   logic [IDX_W-1:0]  sq_idx;
   logic [IDX_W-1:0]  sec_idx;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W:0]    ones_below;
   logic              per_q;
   logic              sec_q;

   prd_ctl_decode #(
      .PRE_FAST (PRE_FAST),
      .PRE_MID  (PRE_MID),
      .PRE_SLOW (PRE_SLOW),
      .IDX_W    (IDX_W)
   ) u_ctl (
      .div_ctl  (div_ctl),
      .ref_kind (ref_kind),
      .active   (active),
      .pre_log2 (pre_log2)
   );

   prd_rate_map #(
      .RATE_W         (RATE_W),
      .SLOW_R1_LOG2   (SLOW_R1_LOG2),
      .SLOW_LOW_CODES (SLOW_LOW_CODES),
      .IDX_W          (IDX_W)
   ) u_rate (
      .rate_sel (rate_sel),
      .ref_kind (ref_kind),
      .pre_log2 (pre_log2),
      .rate_on  (rate_on),
      .tap_idx  (tap_idx)
   );

   prd_chain #(
      .CNT_W (CNT_W)
   ) u_chain (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (!active),
      .adv        (active && ref_en),
      .cnt        (cnt),
      .ones_below (ones_below)
   );

   always_comb begin
      sq_idx  = tap_idx - ONE_I;
      sec_idx = pre_log2 + SEC_SHIFT;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         per_q <= 1'b0;
         sec_q <= 1'b0;
      end else begin
         per_q <= active && rate_on && ref_en && ones_below[tap_idx];
         sec_q <= active && ref_en && ones_below[sec_idx] && !cnt[sec_idx];
      end
   end

   assign per_pulse = per_q;
   assign per_irq   = per_q && pie_en;
   assign sec_tick  = sec_q;
   assign sqw_out   = sqw_en && active && rate_on && cnt[sq_idx];

   AST_HOLD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && $past(!active)) |-> (!per_pulse && !sec_tick))
      else $error("output while chain held"); // R1

   AST_RATE_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (!rate_on && $past(!rate_on)) |-> !per_pulse)
      else $error("pulse with rate code zero"); // R4

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      per_pulse |=> !per_pulse)
      else $error("periodic pulse wider than one cycle"); // R5

   AST_PULSE_NEEDS_REF: assert property (@(posedge clk) disable iff (!rst_n)
      per_pulse |-> $past(ref_en))
      else $error("periodic pulse without reference tick"); // R5

   AST_SEC_NEEDS_REF: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |-> $past(ref_en))
      else $error("second tick without reference tick"); // R8

endmodule

// File: tb/periodic_rate_divider_tb.sv
module periodic_rate_divider_tb_top;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       ref_en;
   logic [2:0] div_ctl;
   logic [3:0] rate_sel;
   logic       sqw_en;
   logic       pie_en;
   logic       per_pulse;
   logic       per_irq;
   logic       sqw_out;
   logic       sec_tick;

   int     n_chk = 0;
   int     n_fail = 0;
   longint cnt_m = 0;
   int     n_pulse, n_sec, n_sqw_hi, n_irq;
   bit     done = 1'b0;

   always #5 clk = ~clk;

   periodic_rate_divider dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ref_en    (ref_en),
      .div_ctl   (div_ctl),
      .rate_sel  (rate_sel),
      .sqw_en    (sqw_en),
      .pie_en    (pie_en),
      .per_pulse (per_pulse),
      .per_irq   (per_irq),
      .sqw_out   (sqw_out),
      .sec_tick  (sec_tick)
   );

   function automatic bit f_valid(logic [2:0] c);
      return c <= 3'd2;
   endfunction

   function automatic int f_pre(logic [2:0] c);
      case (c)
         3'd0:    return 7;
         3'd1:    return 5;
         default: return 0;
      endcase
   endfunction

   function automatic int f_tap(logic [2:0] c, logic [3:0] r);
      if (c == 3'd2 && r <= 4'd2) return f_pre(c) + int'(r) + 6;
      return f_pre(c) + int'(r) - 1;
   endfunction

   function automatic longint f_period(logic [2:0] c, logic [3:0] r);
      return longint'(1) << f_tap(c, r);
   endfunction

   task automatic chk(bit ok, string tag, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic clr_counts();
      n_pulse = 0; n_sec = 0; n_sqw_hi = 0; n_irq = 0;
   endtask

   task automatic step();
      bit     v, on, ep, es, eq;
      int     tp, sidx;
      longint per;
      v    = f_valid(div_ctl);
      on   = (rate_sel != 4'd0);
      tp   = on ? f_tap(div_ctl, rate_sel) : 1;
      sidx = f_pre(div_ctl) + 14;
      per  = longint'(1) << tp;
      ep   = v && on && ref_en && ((cnt_m % per) == per - 1);
      es   = v && ref_en && ((cnt_m % (longint'(1) << (sidx + 1))) == (longint'(1) << sidx) - 1);
      if (!v) cnt_m = 0;
      else if (ref_en) cnt_m = cnt_m + 1;
      @(posedge clk);
      @(negedge clk);
      eq = v && on && sqw_en && (((cnt_m >> (tp - 1)) & 1) == 1);
      chk(per_pulse == ep, "R5 per_pulse", longint'(per_pulse), longint'(ep));
      chk(per_irq == (ep && pie_en), "R6 per_irq", longint'(per_irq), longint'(ep && pie_en));
      chk(sqw_out == eq, "R7 sqw_out", longint'(sqw_out), longint'(eq));
      chk(sec_tick == es, "R8 sec_tick", longint'(sec_tick), longint'(es));
      if (per_pulse) n_pulse++;
      if (sec_tick)  n_sec++;
      if (sqw_out)   n_sqw_hi++;
      if (per_irq)   n_irq++;
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic restart(logic [2:0] c, logic [3:0] r);
      div_ctl = 3'd7;
      ref_en  = 1'b1;
      step();
      div_ctl  = c;
      rate_sel = r;
      clr_counts();
   endtask

   task automatic steps_to_pulse(int limit, output int k);
      k = 0;
      do begin
         step();
         k++;
      end while (!per_pulse && k < limit);
   endtask

   task automatic t_period(logic [2:0] c, logic [3:0] r, string tag);
      int     k;
      longint p;
      p = f_period(c, r);
      restart(c, r);
      steps_to_pulse(int'(p) + 8, k);
      chk(k == p, tag, k, p);
      steps_to_pulse(int'(p) + 8, k);
      chk(k == p, tag, k, p);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int k;
      void'($urandom(32'd4711));
      rst_n = 1'b0; ref_en = 1'b0; div_ctl = 3'd0; rate_sel = 4'd0;
      sqw_en = 1'b0; pie_en = 1'b0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!per_pulse && !per_irq && !sqw_out && !sec_tick, "R1 reset outputs",
          longint'({per_pulse, per_irq, sqw_out, sec_tick}), 0);
      rst_n = 1'b1;
      cnt_m = 0;
      sqw_en = 1'b1;
      pie_en = 1'b1;

      // R3 low rate codes per reference
      t_period(3'd0, 4'd1, "R3 fast code1");
      t_period(3'd1, 4'd1, "R3 mid code1");
      t_period(3'd1, 4'd2, "R3 mid code2");
      t_period(3'd2, 4'd1, "R3 slow code1");
      t_period(3'd2, 4'd2, "R3 slow code2");
      // R2 shifted rates
      t_period(3'd0, 4'd3, "R2 fast code3");
      t_period(3'd1, 4'd4, "R2 mid code4");
      t_period(3'd2, 4'd3, "R2 slow code3");
      t_period(3'd2, 4'd6, "R2 slow code6");

      // R4 rate code zero
      restart(3'd0, 4'd0);
      run(600);
      chk(n_pulse == 0, "R4 no pulse", n_pulse, 0);
      chk(n_sqw_hi == 0, "R4 sqw low", n_sqw_hi, 0);

      // R6 interrupt gate
      restart(3'd1, 4'd1);
      pie_en = 1'b0;
      run(200);
      chk(n_irq == 0, "R6 gated off", n_irq, 0);
      chk(n_pulse == 6, "R6 pulses present", n_pulse, 6);
      clr_counts();
      pie_en = 1'b1;
      run(200);
      chk(n_irq == n_pulse, "R6 gated on", n_irq, n_pulse);

      // R7 duty cycle and enable
      restart(3'd2, 4'd3);
      run(400);
      chk(n_sqw_hi == 200, "R7 half high", n_sqw_hi, 200);
      clr_counts();
      sqw_en = 1'b0;
      run(100);
      chk(n_sqw_hi == 0, "R7 disabled low", n_sqw_hi, 0);
      sqw_en = 1'b1;

      // R1 hold codes and restart phase
      restart(3'd2, 4'd3);
      run(2);
      div_ctl = 3'd5;
      clr_counts();
      run(50);
      chk(n_pulse == 0 && n_sec == 0 && n_sqw_hi == 0, "R1 held quiet",
          n_pulse + n_sec + n_sqw_hi, 0);
      div_ctl = 3'd2;
      steps_to_pulse(20, k);
      chk(k == 4, "R1 restart from zero", k, 4);
      run(1);
      div_ctl = 3'd3;
      clr_counts();
      run(30);
      chk(n_pulse == 0, "R1 code3 hold", n_pulse, 0);

      // R9 stall
      restart(3'd2, 4'd3);
      run(3);
      ref_en = 1'b0;
      clr_counts();
      run(40);
      chk(n_pulse == 0 && n_sqw_hi == 40, "R9 stalled", n_pulse, 0);
      ref_en = 1'b1;
      step();
      chk(per_pulse == 1'b1, "R9 resume", longint'(per_pulse), 1);

      // R8 one-second tick at the slow reference
      restart(3'd2, 4'd0);
      k = 0;
      do begin step(); k++; end while (!sec_tick && k < 20000);
      chk(k == 16384, "R8 first tick", k, 16384);
      k = 0;
      do begin step(); k++; end while (!sec_tick && k < 40000);
      chk(k == 32768, "R8 tick period", k, 32768);

      // random mix against the model (R5 R6 R7 R8 R9)
      for (int s = 0; s < 30; s++) begin
         int pct;
         div_ctl  = 3'($urandom_range(0, 7));
         if ($urandom_range(0, 3) != 0) div_ctl = 3'd2;
         rate_sel = 4'($urandom_range(0, 15));
         sqw_en   = 1'($urandom_range(0, 1));
         pie_en   = 1'($urandom_range(0, 1));
         pct      = $urandom_range(30, 100);
         for (int i = 0; i < 1000; i++) begin
            ref_en = ($urandom_range(1, 100) <= pct);
            step();
         end
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule